// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the registers behind a row of 8-bit general-purpose I/O ports in a small microcontroller. Each port owns three registers at three consecutive I/O addresses: a read-only sampled-pin register, a direction register and an output register. The output register drives the pad while the pin is an output and turns on the pull-up while it is an input. The pad inputs pass through a two-flop synchroniser before they can be read.

The CPU reaches the bank through a request channel with a valid/ready handshake and a one-cycle response. Each request carries an opcode (read, write, bit set, bit clear, bit test), a view flag and an address. The short I/O view (view flag 0) takes I/O addresses 0x00 to 0x3F directly. The data view (view flag 1) reaches the same registers at the I/O address plus 0x20. Bit set and bit clear run as a two-cycle read-modify-write of the whole register. Single-bit operations are honoured only in the lowest 32 I/O locations of the short view.

A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request stable while `req_ready` is low. `req_ready` drops for exactly one cycle after a bit set or bit clear is taken, and that cycle is the write-back phase. Reads and bit tests always produce a response one cycle after they are taken, because the requester cannot stall the response.

Top module: `gpio_bank`

## Requirements
- R1: Port k is decoded at I/O address 3k (sampled pins, read-only), 3k+1 (direction) and 3k+2 (output), for k from 0 to NUM_PORTS-1. A read returns the addressed register.
- R2: With `req_space`=0, I/O addresses 0x00..0x3F are used as given. With `req_space`=1, address A reaches I/O address A-0x20 for A in 0x20..0x5F. Both views reach the same storage.
- R3: The following accesses are misses: a short-view address of 0x40 or above, a data-view address below 0x20 or at 0x60 and above, and any I/O address with no port register. A miss reads 0x00 and a write to it changes nothing.
- R4: Opcode 2 (bit set) and opcode 3 (bit clear) change only bit `req_bit` of the target register. The write happens at the edge after acceptance, and `req_ready` is low in the cycle between those two edges.
- R5: A bit set or bit clear issued in the data view, or to an I/O address of 0x20 or above, changes no register. A bit test issued there returns `rsp_bit`=0 and `rsp_rdata`=0x00.
- R6: Opcode 4 (bit test) returns the addressed bit on `rsp_bit` and the whole register on `rsp_rdata`.
- R7: The sampled-pin register shows `pin_in` through two flops. A level applied before edge e is returned by a read accepted at edge e+2 or later.
- R8: Writes and bit set/clear aimed at a sampled-pin register have no effect.
- R9: Reset clears every direction and output register to 0x00 and both synchroniser stages to 0. It leaves `req_ready` high and `rsp_valid` low.
- R10: `pin_oe` equals the direction registers and `pin_out` equals the output registers. `pin_pu` is high on each bit whose output register bit is 1 and whose direction bit is 0.
- R11: Opcode 0 (read) and opcode 4 raise `rsp_valid` for one cycle, one cycle after they are taken. Opcode 1 (write) and the bit set/clear opcodes raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_op | input | 3 | 0 read, 1 write, 2 bit set, 3 bit clear, 4 bit test |
| req_space | input | 1 | 0 short I/O view, 1 data view |
| req_addr | input | AW | Address in the selected view |
| req_bit | input | $clog2(DW) | Bit index for single-bit operations |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_rdata | output | DW | Read value |
| rsp_bit | output | 1 | Bit-test result |
| pin_in | input | NUM_PORTS*DW | Pad input levels, port k at bits [k*DW +: DW] |
| pin_out | output | NUM_PORTS*DW | Output register contents |
| pin_oe | output | NUM_PORTS*DW | Output enables from the direction registers |
| pin_pu | output | NUM_PORTS*DW | Pull-up enables |

## Verification
Directed accesses write the same register through both views and read it back through the other one. This separates a wrong 0x20 offset from a wrong per-port stride. A second set of accesses aims at miss addresses on each side of the 0x20, 0x40 and 0x60 boundaries and at the unused locations above the last port, which exposes a decoder that aliases. Bit set and bit clear are issued back to back with reads, both in the permitted low window and through the data view. This shows whether the write-back lands one edge later, whether the stall lasts exactly one cycle, and whether a rejected operation still writes. Pin changes are timed against reads to expose a synchroniser that is one stage too short or too long. A long random stream then mixes all opcodes and pin changes against the bench model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_BSET = 3'd2,
    OP_BCLR = 3'd3,
    OP_BTST = 3'd4
  } gpio_op_e;

  typedef enum logic [1:0] {
    SEL_PIN = 2'd0,
    SEL_DIR = 2'd1,
    SEL_OUT = 2'd2
  } gpio_sel_e;

  localparam int REGS_PER_PORT = 3;
  localparam int IO_SPAN       = 64;
  localparam int BIT_SPAN      = 32;
  localparam int DATA_OFS      = 32;
  localparam int IO_AW         = $clog2(IO_SPAN);
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec import gpio_pkg::*; #(
  parameter int NUM_PORTS = 5,
  parameter int AW        = 9,
  parameter int PW        = 3
) (
  input  logic          space,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [PW-1:0] port,
  output gpio_sel_e     sel,
  output logic          bit_ok
);
  logic             view_ok;
  logic [IO_AW-1:0] io_addr;

  always_comb begin
    view_ok = 1'b0;
    io_addr = '0;
    if (!space) begin
      view_ok = (int'(addr) < IO_SPAN);
      io_addr = addr[IO_AW-1:0];
    end else begin
      view_ok = (int'(addr) >= DATA_OFS) && (int'(addr) < DATA_OFS + IO_SPAN);
      io_addr = IO_AW'(int'(addr) - DATA_OFS);
    end
  end

  // single-bit operations only through the short view, low window
  assign bit_ok = !space && (int'(addr) < BIT_SPAN);

  always_comb begin
    hit  = 1'b0;
    port = '0;
    sel  = SEL_PIN;
    for (int k = 0; k < NUM_PORTS; k++) begin
      for (int j = 0; j < REGS_PER_PORT; j++) begin
        if (view_ok && int'(io_addr) == REGS_PER_PORT * k + j) begin
          hit  = 1'b1;
          port = PW'(k);
          sel  = gpio_sel_e'(j);
        end
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_dir,
  input  logic          we_out,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (we_dir) dir_q <= wdata;
      if (we_out) out_q <= wdata;
    end
  end

  // R8 / R3: storage only moves on its own enable
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dir |=> $stable(dir_q));
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_out |=> $stable(out_q));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_pkg::*; #(
  parameter int NUM_PORTS = 5,
  parameter int DW        = 8,
  parameter int AW        = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic                    req_space,
  input  logic [AW-1:0]           req_addr,
  input  logic [$clog2(DW)-1:0]   req_bit,
  input  logic [DW-1:0]           req_wdata,
  output logic                    rsp_valid,
  output logic [DW-1:0]           rsp_rdata,
  output logic                    rsp_bit,
  input  logic [NUM_PORTS*DW-1:0] pin_in,
  output logic [NUM_PORTS*DW-1:0] pin_out,
  output logic [NUM_PORTS*DW-1:0] pin_oe,
  output logic [NUM_PORTS*DW-1:0] pin_pu
);
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int BW = $clog2(DW);
  localparam int TW = NUM_PORTS * DW;

  gpio_op_e  op;
  logic      accept, is_bitop, is_rsp;
  logic      dec_hit, dec_bit_ok;
  logic [PW-1:0] dec_port;
  gpio_sel_e dec_sel;

  logic [TW-1:0] pin_sync;
  logic [DW-1:0] dir_v [NUM_PORTS];
  logic [DW-1:0] out_v [NUM_PORTS];
  logic [DW-1:0] rd_val;

  logic          busy_q, pend_we_q, pend_dir_q, pend_set_q;
  logic [PW-1:0] pend_port_q;
  logic [BW-1:0] pend_bit_q;
  logic [DW-1:0] rmw_base, rmw_val, wr_data;
  logic [NUM_PORTS-1:0] we_dir, we_out;

  assign op        = gpio_op_e'(req_op);
  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign is_bitop  = (op == OP_BSET) || (op == OP_BCLR);
  assign is_rsp    = (op == OP_RD) || (op == OP_BTST);

  gpio_addr_dec #(.NUM_PORTS(NUM_PORTS), .AW(AW), .PW(PW)) u_dec (
    .space  (req_space),
    .addr   (req_addr),
    .hit    (dec_hit),
    .port   (dec_port),
    .sel    (dec_sel),
    .bit_ok (dec_bit_ok)
  );

  gpio_sync #(.W(TW)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (pin_in),
    .q   (pin_sync)
  );

  // read mux
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (dec_hit && dec_port == PW'(k)) begin
        case (dec_sel)
          SEL_DIR: rd_val = dir_v[k];
          SEL_OUT: rd_val = out_v[k];
          default: rd_val = pin_sync[k*DW +: DW];
        endcase
      end
    end
  end

  // read-modify-write sequencer: phase 1 accepts, phase 2 writes back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pend_we_q   <= 1'b0;
      pend_dir_q  <= 1'b0;
      pend_set_q  <= 1'b0;
      pend_port_q <= '0;
      pend_bit_q  <= '0;
    end else if (busy_q) begin
      busy_q    <= 1'b0;
      pend_we_q <= 1'b0;
    end else if (accept && is_bitop) begin
      busy_q      <= 1'b1;
      pend_we_q   <= dec_hit && dec_bit_ok && (dec_sel != SEL_PIN);
      pend_dir_q  <= (dec_sel == SEL_DIR);
      pend_set_q  <= (op == OP_BSET);
      pend_port_q <= dec_port;
      pend_bit_q  <= req_bit;
    end
  end

  always_comb begin
    rmw_base = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (pend_port_q == PW'(k)) rmw_base = pend_dir_q ? dir_v[k] : out_v[k];
    end
    rmw_val = rmw_base;
    rmw_val[pend_bit_q] = pend_set_q;
  end

  assign wr_data = pend_we_q ? rmw_val : req_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_port
      logic direct_hit;
      assign direct_hit = accept && (op == OP_WR) && dec_hit && (dec_port == PW'(g));
      assign we_dir[g] = (direct_hit && dec_sel == SEL_DIR) ||
                         (pend_we_q && pend_port_q == PW'(g) && pend_dir_q);
      assign we_out[g] = (direct_hit && dec_sel == SEL_OUT) ||
                         (pend_we_q && pend_port_q == PW'(g) && !pend_dir_q);

      gpio_port #(.DW(DW)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_dir (we_dir[g]),
        .we_out (we_out[g]),
        .wdata  (wr_data),
        .dir_q  (dir_v[g]),
        .out_q  (out_v[g])
      );

      assign pin_oe [g*DW +: DW] = dir_v[g];
      assign pin_out[g*DW +: DW] = out_v[g];
      assign pin_pu [g*DW +: DW] = out_v[g] & ~dir_v[g];
    end
  endgenerate

  // response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_bit   <= 1'b0;
    end else begin
      rsp_valid <= accept && is_rsp;
      if (accept && op == OP_RD) begin
        rsp_rdata <= rd_val;
        rsp_bit   <= 1'b0;
      end else if (accept && op == OP_BTST) begin
        rsp_rdata <= dec_bit_ok ? rd_val : '0;
        rsp_bit   <= dec_bit_ok && rd_val[req_bit];
      end
    end
  end

  p_stall_after_bitop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_bitop |=> !req_ready);
  p_stall_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  p_reject_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_bitop && !dec_bit_ok |=> !pend_we_q);
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_rsp |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && is_rsp) |=> !rsp_valid);
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_dir, we_out}));
  p_pull_only_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int NP = 5;
  localparam int DW = 8;
  localparam int AW = 9;
  localparam int TW = NP * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic          req_space = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_bit = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_bit;
  logic [TW-1:0] pin_in = '0;
  logic [TW-1:0] pin_out, pin_oe, pin_pu;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R9";

  // behavioural reference state
  logic [DW-1:0] m_dir [NP];
  logic [DW-1:0] m_out [NP];
  logic [TW-1:0] m_s1, m_s2;
  bit m_busy, m_pw, m_pdir, m_pset;
  int m_pport, m_pbit;
  bit m_rv, m_rb;
  logic [DW-1:0] m_rd;

  always #4 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_space(req_space), .req_addr(req_addr), .req_bit(req_bit),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_bit(rsp_bit), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu)
  );

  function automatic int io_of(bit sp, int a);
    if (!sp) return (a < 64) ? a : -1;
    return (a >= 32 && a < 96) ? a - 32 : -1;
  endfunction

  function automatic logic [DW-1:0] m_read(int io);
    if (io < 0 || io >= 3 * NP) return '0;
    case (io % 3)
      0: return m_s2[(io / 3) * DW +: DW];
      1: return m_dir[io / 3];
      default: return m_out[io / 3];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) begin m_dir[k] = '0; m_out[k] = '0; end
      m_s1 = '0; m_s2 = '0; m_busy = 0; m_pw = 0; m_rv = 0; m_rb = 0; m_rd = '0;
    end else begin
      int io;
      logic [DW-1:0] v;
      bit okb;
      io = io_of(req_space, int'(req_addr));
      v = m_read(io);
      okb = !req_space && int'(req_addr) < 32;
      m_rv = 0;
      if (m_busy) begin
        if (m_pw) begin
          if (m_pdir) m_dir[m_pport][m_pbit] = m_pset;
          else        m_out[m_pport][m_pbit] = m_pset;
        end
        m_busy = 0;
      end else if (req_valid) begin
        case (req_op)
          3'd0: begin m_rv = 1; m_rd = v; m_rb = 0; end
          3'd1: if (io >= 0 && io < 3 * NP) begin
                  if (io % 3 == 1) m_dir[io / 3] = req_wdata;
                  if (io % 3 == 2) m_out[io / 3] = req_wdata;
                end
          3'd2, 3'd3: begin
            m_busy = 1;
            m_pw = okb && io >= 0 && io < 3 * NP && (io % 3 != 0);
            m_pdir = (io % 3 == 1);
            m_pport = (io >= 0) ? io / 3 : 0;
            m_pbit = int'(req_bit);
            m_pset = (req_op == 3'd2);
          end
          3'd4: begin
            m_rv = 1;
            m_rd = okb ? v : '0;
            m_rb = okb && v[req_bit];
          end
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      logic [TW-1:0] eo, ed, ep;
      for (int k = 0; k < NP; k++) begin
        ed[k*DW +: DW] = m_dir[k];
        eo[k*DW +: DW] = m_out[k];
        ep[k*DW +: DW] = m_out[k] & ~m_dir[k];
      end
      chk(req_ready == !m_busy, "req_ready", req_ready, !m_busy);
      chk(rsp_valid == m_rv, "rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk(rsp_rdata == m_rd, "rsp_rdata", rsp_rdata, m_rd);
        chk(rsp_bit == m_rb, "rsp_bit", rsp_bit, m_rb);
      end
      chk(pin_oe == ed, "pin_oe R10", pin_oe, ed);
      chk(pin_out == eo, "pin_out R10", pin_out, eo);
      chk(pin_pu == ep, "pin_pu R10", pin_pu, ep);
    end
  end

  // issue at a negedge; returns at the negedge after acceptance
  task automatic req(input int op, input bit sp, input int a, input int b, input int wd);
    bit r;
    req_valid = 1; req_op = 3'(op); req_space = sp;
    req_addr = AW'(a); req_bit = 3'(b); req_wdata = DW'(wd);
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic rd_expect(input bit sp, input int a, input int exp, input string t);
    tag = t;
    req(0, sp, a, 0, 0);
    chk(rsp_valid && rsp_rdata == DW'(exp), "directed read", rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R9";
    chk(pin_oe == '0 && pin_out == '0 && req_ready && !rsp_valid, "reset state", pin_oe, 0);
    rd_expect(0, 8'h01, 8'h00, "R9");

    // R1 / R10 port A direct writes
    tag = "R1";
    req(1, 0, 8'h01, 0, 8'hF0);
    req(1, 0, 8'h02, 0, 8'h3C);
    idle();
    tag = "R10";
    chk(pin_pu[7:0] == 8'h0C, "pull-up A", pin_pu[7:0], 8'h0C);
    rd_expect(0, 8'h01, 8'hF0, "R1");
    rd_expect(0, 8'h02, 8'h3C, "R1");

    // R2 data view aliases
    tag = "R2";
    req(1, 1, 8'h24, 0, 8'h5A);
    rd_expect(0, 8'h04, 8'h5A, "R2");
    rd_expect(1, 8'h22, 8'h3C, "R2");
    req(1, 1, 8'h2E, 0, 8'h81);
    rd_expect(0, 8'h0E, 8'h81, "R2");

    // R3 misses
    tag = "R3";
    req(1, 0, 8'h0F, 0, 8'hFF);
    req(1, 1, 8'h01, 0, 8'hFF);
    req(1, 1, 8'h61, 0, 8'hFF);
    req(1, 0, 9'h041, 0, 8'hFF);
    req(1, 1, 9'h1FF, 0, 8'hFF);
    rd_expect(0, 8'h0F, 8'h00, "R3");
    rd_expect(1, 8'h60, 8'h00, "R3");
    rd_expect(0, 8'h01, 8'hF0, "R3");
    rd_expect(0, 8'h02, 8'h3C, "R3");

    // R7 synchroniser latency, R8 pin register read-only
    tag = "R7";
    idle();
    pin_in[23:16] = 8'hA7;
    req(0, 0, 8'h06, 0, 0);
    req(0, 0, 8'h06, 0, 0);
    rd_expect(0, 8'h06, 8'hA7, "R7");
    tag = "R8";
    req(1, 0, 8'h06, 0, 8'h00);
    req(2, 0, 8'h03, 4, 0);
    rd_expect(0, 8'h06, 8'hA7, "R8");
    rd_expect(0, 8'h03, 8'h00, "R8");

    // R4 / R6 bit operations back to back
    tag = "R4";
    req(2, 0, 8'h02, 0, 0);
    req(3, 0, 8'h02, 5, 0);
    req(2, 0, 8'h0D, 7, 0);
    rd_expect(0, 8'h02, 8'h1D, "R4");
    rd_expect(0, 8'h0D, 8'h80, "R4");
    tag = "R6";
    req(4, 0, 8'h0D, 7, 0);
    chk(rsp_valid && rsp_bit && rsp_rdata == 8'h80, "bit test", rsp_bit, 1);
    req(4, 0, 8'h0D, 6, 0);
    chk(rsp_valid && !rsp_bit, "bit test zero", rsp_bit, 0);

    // R5 rejected bit operations
    tag = "R5";
    req(3, 1, 8'h22, 0, 0);
    req(2, 1, 8'h24, 0, 0);
    rd_expect(0, 8'h02, 8'h1D, "R5");
    rd_expect(0, 8'h04, 8'h5A, "R5");
    req(4, 1, 8'h22, 0, 0);
    chk(rsp_valid && !rsp_bit && rsp_rdata == 8'h00, "rejected test", rsp_bit, 0);

    // R11 mixed random stream checked by the model every cycle
    tag = "R11";
    for (int i = 0; i < 600; i++) begin
      int op, a;
      bit sp;
      op = $urandom_range(0, 4);
      sp = 1'($urandom_range(0, 1));
      a = sp ? $urandom_range(0, 111) : $urandom_range(0, 20);
      if ($urandom_range(0, 7) == 0) pin_in = TW'({$urandom, $urandom});
      req(op, sp, a, $urandom_range(0, 7), $urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule